// File: doc/BRIEF.md
# Zero-Skipping CRC-16 Remainder Engine

This block finishes a CRC-16 long division over a short message tail. Software or an upstream engine provides a 16-bit running remainder (the seed) and a 24-bit data word. Only the low eight bits of the data word are divided in, most significant bit first. The generator is x^16 + x^12 + x^5 + 1, so the constant XORed into the remainder is 0x1021.

The engine does not step one bit per clock. In each busy cycle it counts the leading zeros of the working remainder. It then retires that run of zeros together with the leading one in a single step, shifting the same number of fresh message bits in from below and applying the polynomial. A message tail therefore takes between one and eight cycles, depending on the bit pattern. A single-cycle `start` pulse loads the operands. `busy` is high while steps run, and `done` pulses when the result in `crc` is ready.

Top module: `crc_skip_engine`

## Requirements
- R1: During and right after reset, `busy` and `done` are 0 and `crc` is 0x0000.
- R2: A `start` sampled while idle loads `seed` into the working remainder and the eight message bits `data[7:0]`. On the following cycle `busy` is 1 and `crc` equals `seed`.
- R3: Each busy cycle computes z, the number of leading zeros of the working remainder (16 when it is zero). It also uses m, the number of message bits still unconsumed. When z+1 < m, the remainder shifts left by z+1, the next z+1 message bits fill the low end, 0x1021 is XORed in, and the engine stays busy.
- R4: When z+1 equals m, the remainder shifts left by m, takes all remaining message bits, and is XORed with 0x1021. The engine then finishes.
- R5: When z+1 exceeds m, the remainder shifts left by m and takes all remaining message bits with no XOR. The engine then finishes.
- R6: The final `crc` equals the remainder of the 24-bit value {seed, data[7:0]} divided by 0x11021 in carry-less (GF(2)) arithmetic.
- R7: `busy` lasts one cycle per division step: one for each polynomial XOR, plus one if the last message bit produced no XOR. This is never more than 8 cycles.
- R8: `done` is high for exactly the one cycle after the last step, with `busy` low. `crc` then holds its value until the next accepted `start`.
- R9: A `start` that arrives while `busy` is 1 has no effect on the running division or its result.
- R10: Bits 23:8 of `data` have no effect on any output.
- R11: A zero seed finishes in one cycle with `crc` = {8'h00, data[7:0]}. A seed with bit 15 set skips no zeros on its first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load seed and data and begin (honoured only when idle) |
| seed | input | 16 | Initial remainder |
| data | input | 24 | Extended data word; bits 7:0 are divided in |
| busy | output | 1 | Division steps in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| crc | output | 16 | Working remainder, final once done pulses |

## Verification
The bench steps a bit-serial model in lockstep with the design and compares `crc`, `busy` and `done` every clock. Each cycle is tagged as a continuing XOR step, an exact-fit final XOR, or a plain final shift. An off-by-one in the skip-versus-remaining comparison would XOR on the wrong cycle or stop early, and the per-cycle remainder would diverge. A mask boundary that is one bit off, or a wrong data slice, would corrupt the low bits of the remainder. Separate cases cover a zero seed (skip of 16), a seed with bit 15 set (skip of 0), a `start` pulse during a run that must not reload, and upper data bits that must not leak into the result.

// File: rtl/crc_skip_pkg.sv
package crc_skip_pkg;

    // Outcome of one division step
    typedef enum logic [1:0] {
        STEP_MORE       = 2'd0,  // XOR applied, message bits remain
        STEP_LAST_XOR   = 2'd1,  // XOR applied on the final message bit
        STEP_LAST_PLAIN = 2'd2   // leading run outlasts the message, no XOR
    } step_kind_e;

endpackage

// File: rtl/crc_lead_zeros.sv
module crc_lead_zeros #(
    parameter int W  = 16,
    localparam int ZW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [ZW-1:0] zeros
);

    // Priority encoder: the highest set bit wins, all-zero gives W
    always_comb begin
        zeros = ZW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                zeros = ZW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/crc_step_decide.sv
module crc_step_decide
    import crc_skip_pkg::*;
#(
    parameter int SKIP_W = 5,
    parameter int CNT_W  = 3,
    parameter int TAKE_W = 4
) (
    input  logic [SKIP_W-1:0] skip,
    input  logic [CNT_W-1:0]  cnt,
    output step_kind_e        kind,
    output logic [TAKE_W-1:0] take,
    output logic [CNT_W-1:0]  lo_pos,
    output logic [CNT_W-1:0]  cnt_next
);

    logic [SKIP_W-1:0] cnt_ext;
    assign cnt_ext = SKIP_W'(cnt);

    always_comb begin
        if (skip < cnt_ext) begin
            kind     = STEP_MORE;
            take     = TAKE_W'(skip) + TAKE_W'(1);
            lo_pos   = cnt - CNT_W'(skip);
            cnt_next = cnt - CNT_W'(skip) - CNT_W'(1);
        end else if (skip == cnt_ext) begin
            kind     = STEP_LAST_XOR;
            take     = TAKE_W'(cnt) + TAKE_W'(1);
            lo_pos   = '0;
            cnt_next = '0;
        end else begin
            kind     = STEP_LAST_PLAIN;
            take     = TAKE_W'(cnt) + TAKE_W'(1);
            lo_pos   = '0;
            cnt_next = '0;
        end
    end

endmodule

// File: rtl/crc_splice.sv
module crc_splice #(
    parameter int              W      = 16,
    parameter int              MSG_W  = 8,
    parameter int              TAKE_W = 4,
    parameter int              POS_W  = 3,
    parameter logic [W-1:0]    POLY   = 16'h1021
) (
    input  logic [W-1:0]      rem,
    input  logic [MSG_W-1:0]  msg,
    input  logic [TAKE_W-1:0] take,
    input  logic [POS_W-1:0]  lo_pos,
    input  logic              xor_en,
    output logic [W-1:0]      next_rem
);

    logic [W-1:0] shifted;
    logic [W-1:0] fill;
    logic [W-1:0] keep_mask;
    logic [W-1:0] merged;

    assign shifted = rem << take;
    assign fill    = W'(msg >> lo_pos);

    // Ones at and above bit `take`, zeros below
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign keep_mask[i] = (32'(take) <= 32'(i));
    end

    assign merged   = (shifted & keep_mask) | (fill & ~keep_mask);
    assign next_rem = xor_en ? (merged ^ POLY) : merged;

endmodule

// File: rtl/crc_skip_engine.sv
module crc_skip_engine
    import crc_skip_pkg::*;
#(
    parameter int                 REM_W    = 16,
    parameter int                 DATA_W   = 24,
    parameter int                 MSG_BITS = 8,
    parameter logic [REM_W-1:0]   POLY     = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REM_W-1:0]  seed,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              done,
    output logic [REM_W-1:0]  crc
);

    localparam int CNT_W    = $clog2(MSG_BITS);
    localparam int SKIP_W   = $clog2(REM_W + 1);
    localparam int TAKE_W   = $clog2(MSG_BITS + 1);
    localparam int CNT_INIT = MSG_BITS - 1;

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [REM_W-1:0]    rem;
        logic [MSG_BITS-1:0] msg;
        logic [CNT_W-1:0]    cnt;
    } eng_t;

    eng_t st_d, st_q;

    logic [SKIP_W-1:0] skip;
    step_kind_e        kind;
    logic [TAKE_W-1:0] take;
    logic [CNT_W-1:0]  lo_pos;
    logic [CNT_W-1:0]  cnt_next;
    logic [REM_W-1:0]  rem_step;
    logic              unused_data_hi;

    assign unused_data_hi = ^data[DATA_W-1:MSG_BITS];

    crc_lead_zeros #(.W(REM_W)) u_lzc (
        .vec   (st_q.rem),
        .zeros (skip)
    );

    crc_step_decide #(
        .SKIP_W (SKIP_W),
        .CNT_W  (CNT_W),
        .TAKE_W (TAKE_W)
    ) u_decide (
        .skip     (skip),
        .cnt      (st_q.cnt),
        .kind     (kind),
        .take     (take),
        .lo_pos   (lo_pos),
        .cnt_next (cnt_next)
    );

    crc_splice #(
        .W      (REM_W),
        .MSG_W  (MSG_BITS),
        .TAKE_W (TAKE_W),
        .POS_W  (CNT_W),
        .POLY   (POLY)
    ) u_splice (
        .rem      (st_q.rem),
        .msg      (st_q.msg),
        .take     (take),
        .lo_pos   (lo_pos),
        .xor_en   (kind != STEP_LAST_PLAIN),
        .next_rem (rem_step)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.rem  = seed;
                st_d.msg  = data[MSG_BITS-1:0];
                st_d.cnt  = CNT_W'(CNT_INIT);
            end
        end else begin
            st_d.rem = rem_step;
            st_d.cnt = cnt_next;
            if (kind != STEP_MORE) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign crc  = st_q.rem;

endmodule

// File: rtl/crc_skip_engine_chk.sv
module crc_skip_engine_chk #(
    parameter int REM_W    = 16,
    parameter int MSG_BITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [REM_W-1:0] seed,
    input logic             busy,
    input logic             done,
    input logic [REM_W-1:0] crc
);

    localparam int RW = $clog2(MSG_BITS + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + RW'(1);
        end else begin
            run_q <= '0;
        end
    end

    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (crc == $past(seed))); // R2
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(MSG_BITS))); // R7
    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc)); // R8

endmodule

bind crc_skip_engine crc_skip_engine_chk #(
    .REM_W    (REM_W),
    .MSG_BITS (MSG_BITS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .seed  (seed),
    .busy  (busy),
    .done  (done),
    .crc   (crc)
);

// File: tb/crc_skip_engine_tb.sv
module crc_skip_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] seed_i = '0;
    logic [23:0] data_i = '0;
    logic        busy;
    logic        done;
    logic [15:0] crc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    crc_skip_engine u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .seed  (seed_i),
        .data  (data_i),
        .busy  (busy),
        .done  (done),
        .crc   (crc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent long division of {seed, msg} by 0x11021
    function automatic logic [15:0] long_div(input logic [15:0] s, input logic [7:0] m);
        logic [23:0] v;
        v = {s, m};
        for (int b = 23; b >= 16; b--) begin
            if (v[b]) v = v ^ (24'h011021 << (b - 16));
        end
        return v[15:0];
    endfunction

    // One division step: shift bits in one at a time until a one leaves the top
    task automatic model_step(inout logic [15:0] r, inout int left, input logic [7:0] m,
                              output bit xored);
        bit top;
        xored = 1'b0;
        while (left > 0) begin
            top  = r[15];
            r    = {r[14:0], m[left-1]};
            left = left - 1;
            if (top) begin
                r     = r ^ 16'h1021;
                xored = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_case(input logic [15:0] sd, input logic [23:0] dt, input bit poke,
                            output logic [15:0] res, output int steps);
        logic [15:0] r;
        int          left;
        bit          xored;
        string       tag;
        @(negedge clk);
        seed_i = sd;
        data_i = dt;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
        check(crc == sd, "R2 seed loaded", 32'(crc), 32'(sd));
        if (poke) begin
            start  = 1'b1;
            seed_i = ~sd;
            data_i = ~dt;
        end
        r     = sd;
        left  = 8;
        steps = 0;
        while (left > 0) begin
            model_step(r, left, dt[7:0], xored);
            steps++;
            if (!xored) tag = "R5";
            else if (left == 0) tag = "R4";
            else tag = "R3";
            @(negedge clk);
            if (poke && steps == 1) start = 1'b0;
            check(crc == r, {tag, " step remainder"}, 32'(crc), 32'(r));
            check(busy == (left > 0), {"R7 busy ", tag}, 32'(busy), 32'(left > 0));
            check(done == (left == 0), {"R8 done ", tag}, 32'(done), 32'(left == 0));
        end
        res = crc;
        check(res == long_div(sd, dt[7:0]), poke ? "R9 result" : "R6 result",
              32'(res), 32'(long_div(sd, dt[7:0])));
        check(steps <= 8, "R7 step count", 32'(steps), 32'd8);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8 done one cycle", {30'd0, busy, done}, 32'd0);
        check(crc == res, "R8 hold", 32'(crc), 32'(res));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] res_a;
        logic [15:0] res_b;
        int          n_a;
        int          n_b;

        repeat (2) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 flags in reset", {30'd0, busy, done}, 32'd0);
        check(crc == 16'h0000, "R1 crc in reset", 32'(crc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 flags after reset", {30'd0, busy, done}, 32'd0);
        check(crc == 16'h0000, "R1 crc after reset", 32'(crc), 32'd0);

        // R11 zero seed: one plain step, data passes straight through
        run_case(16'h0000, 24'hABCD5A, 1'b0, res_a, n_a);
        check(res_a == 16'h005A, "R11 zero seed result", 32'(res_a), 32'h005A);
        check(n_a == 1, "R11 zero seed cycles", 32'(n_a), 32'd1);

        // R11 top bit set: no leading zeros on the first step
        run_case(16'h8000, 24'h000000, 1'b0, res_a, n_a);
        run_case(16'hFFFF, 24'h0000FF, 1'b0, res_a, n_a);
        run_case(16'h0080, 24'h000001, 1'b0, res_a, n_a);
        run_case(16'h0100, 24'h000000, 1'b0, res_a, n_a);
        run_case(16'h0001, 24'h0000FF, 1'b0, res_a, n_a);

        // R10: upper data bits must not change the result
        run_case(16'h1234, 24'h0000A7, 1'b0, res_a, n_a);
        run_case(16'h1234, 24'hFFFFA7, 1'b0, res_b, n_b);
        check(res_a == res_b, "R10 upper bits ignored", 32'(res_b), 32'(res_a));
        check(n_a == n_b, "R10 cycle count unchanged", 32'(n_b), 32'(n_a));

        // R9: start pulses during a run are ignored
        run_case(16'hC3A5, 24'h00003C, 1'b1, res_a, n_a);
        run_case(16'h8001, 24'h000080, 1'b1, res_a, n_a);

        for (int k = 0; k < 60; k++) begin
            run_case(16'($urandom), 24'($urandom), k % 7 == 3, res_a, n_a);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule